// File: doc/BRIEF.md
# Built-In Self-Test Pattern and Signature Engine

This block runs a self-test on a nearby circuit. On a start request it reseeds a 9-bit pseudo-random pattern source and clears a response compactor. It then presents one test pattern per clock. The pattern appears both as a parallel word and as a serial bit taken from the most significant stage. In the same cycle the circuit under test returns a response word, and the compactor folds that word into a running signature.

The pattern source is a maximal-length shift register with internal XOR feedback. It normally visits every nonzero 9-bit value exactly once per run. An optional zero-insertion mode adds the all-zero word, so that all 512 codes are applied. At the end of the run the folded signature is compared with a known-good value supplied on an input. A one-cycle completion pulse is issued, and a pass or fail verdict is held until the next run starts.

Top module: `bist_engine`

## Requirements
- R1: After reset, pattern_o is the seed 9'h001, and busy_o, done_o, pass_o and fail_o are all 0.
- R2: Each advance maps the pattern s to n, where n[0]=s[8], n[5]=s[4]^s[8] and n[i]=s[i-1] for every other bit (polynomial x^9+x^5+1). serial_o always equals pattern_o[8].
- R3: With zero insertion off, a run applies 511 patterns starting at the seed, all distinct and none equal to zero.
- R4: With zero insertion on, the all-zero pattern follows 9'h001 and is followed by 9'h002, so a run applies 512 distinct patterns.
- R5: zero_ins_i is sampled only on the cycle a start is accepted. Changes to it during a run have no effect.
- R6: An accepted start clears the signature to zero. On each run cycle the signature becomes the R2 advance of itself, XORed with resp_i.
- R7: busy_o is high for exactly as many cycles as the run has patterns. done_o is high for exactly the one cycle after busy_o falls.
- R8: When done_o rises, pass_o is 1 if the final signature equals golden_i as sampled in the last run cycle, and fail_o is its complement. Both hold until the next accepted start, which clears them.
- R9: A start request while busy_o is high is ignored, and the run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a test run when idle |
| zero_ins_i | input | 1 | Select all-zero insertion for the run being started |
| resp_i | input | 9 | Response word from the circuit under test for the current pattern |
| golden_i | input | 9 | Known-good signature, sampled in the last run cycle |
| pattern_o | output | 9 | Current parallel test pattern |
| serial_o | output | 1 | Serial test bit, the pattern MSB |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle run completion pulse |
| pass_o | output | 1 | Final signature matched the known-good value |
| fail_o | output | 1 | Final signature did not match |

## Verification
The bench compares every applied pattern with an independent model. It tracks the visited codes in a bitmap, so a wrong injection tap, a missing or misplaced zero state, or an off-by-one run length would show up as a repeated code, a stray zero or a wrong busy count. Signatures are checked with random, all-zero and all-ones responses, against both matching and single-bit-wrong golden words. A compactor that used the wrong feedback, dropped the last word, or kept stale state from an earlier run would report the wrong verdict. The bench toggles the mode input and pulses start in the middle of runs, so a design that re-sampled either one would change the length or the sequence of the run.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bist_state_e;
endpackage

// File: rtl/bist_galois_step.sv
// One advance of an internal-XOR shift register, shifting toward the MSB.
// The MSB wraps to bit 0 and is also folded into stage INJ_STAGE (1-based).
module bist_galois_step #(
    parameter int WIDTH     = 9,
    parameter int INJ_STAGE = 6
) (
    input  logic [WIDTH-1:0] cur_i,
    output logic [WIDTH-1:0] nxt_o
);
    localparam int INJ_BIT = INJ_STAGE - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_wrap
            assign nxt_o[i] = cur_i[WIDTH-1];
        end else if (i == INJ_BIT) begin : g_inj
            assign nxt_o[i] = cur_i[i-1] ^ cur_i[WIDTH-1];
        end else begin : g_shift
            assign nxt_o[i] = cur_i[i-1];
        end
    end
endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
    parameter int           WIDTH     = 9,
    parameter int           INJ_STAGE = 6,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic             zero_en_i,
    output logic [WIDTH-1:0] pat_o
);
    localparam logic [WIDTH-1:0] ONE_W     = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] SEED_SAFE = (SEED == '0) ? ONE_W : SEED;

    logic [WIDTH-1:0] pat_d, pat_q;
    logic [WIDTH-1:0] step_w, after_one_w;

    bist_galois_step #(.WIDTH(WIDTH), .INJ_STAGE(INJ_STAGE)) u_step (
        .cur_i (pat_q),
        .nxt_o (step_w)
    );

    bist_galois_step #(.WIDTH(WIDTH), .INJ_STAGE(INJ_STAGE)) u_step_one (
        .cur_i (ONE_W),
        .nxt_o (after_one_w)
    );

    always_comb begin
        pat_d = pat_q;
        if (load_i) begin
            pat_d = SEED_SAFE;
        end else if (adv_i) begin
            if (zero_en_i && (pat_q == ONE_W)) begin
                pat_d = '0;
            end else if (zero_en_i && (pat_q == '0)) begin
                pat_d = after_one_w;
            end else begin
                pat_d = step_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= SEED_SAFE;
        else        pat_q <= pat_d;
    end

    assign pat_o = pat_q;

    // R4: the zero pattern is only ever entered from 9'h001
    a_r4_zero_after_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_q == '0) |-> ($past(pat_q) == ONE_W));

    // R3: without zero insertion the register never holds zero
    a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_en_i && !$past(zero_en_i)) |-> (pat_q != '0));

    // R2: idle register holds its value
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(pat_q));
endmodule

// File: rtl/bist_sig_reg.sv
module bist_sig_reg #(
    parameter int WIDTH     = 9,
    parameter int INJ_STAGE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             absorb_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] sig_next_o
);
    logic [WIDTH-1:0] sig_d, sig_q;
    logic [WIDTH-1:0] step_w;

    bist_galois_step #(.WIDTH(WIDTH), .INJ_STAGE(INJ_STAGE)) u_step (
        .cur_i (sig_q),
        .nxt_o (step_w)
    );

    always_comb begin
        sig_d = sig_q;
        if (clear_i)       sig_d = '0;
        else if (absorb_i) sig_d = step_w ^ data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig_next_o = sig_d;

    // R6: a cleared signature reads zero on the next cycle
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sig_q == '0));

    // R6: no absorb, no change
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !absorb_i) |=> $stable(sig_q));
endmodule

// File: rtl/bist_engine.sv
module bist_engine
    import bist_pkg::*;
#(
    parameter int               WIDTH     = 9,
    parameter int               INJ_STAGE = 6,
    parameter logic [WIDTH-1:0] SEED      = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             zero_ins_i,
    input  logic [WIDTH-1:0] resp_i,
    input  logic [WIDTH-1:0] golden_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic             serial_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o
);
    localparam int           CW        = WIDTH + 1;
    localparam logic [CW-1:0] LAST_ALL = CW'((1 << WIDTH) - 1);
    localparam logic [CW-1:0] LAST_NZ  = CW'((1 << WIDTH) - 2);

    typedef struct packed {
        bist_state_e      st;
        logic [CW-1:0]    cnt;
        logic             zmode;
        logic             done;
        logic             pass;
        logic             fail;
    } ctrl_t;

    ctrl_t            ctl_d, ctl_q;
    logic             start_ok;
    logic             running;
    logic [CW-1:0]    last_idx;
    logic [WIDTH-1:0] sig_next;

    bist_pattern_gen #(.WIDTH(WIDTH), .INJ_STAGE(INJ_STAGE), .SEED(SEED)) u_pat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_ok),
        .adv_i     (running),
        .zero_en_i (ctl_q.zmode),
        .pat_o     (pattern_o)
    );

    bist_sig_reg #(.WIDTH(WIDTH), .INJ_STAGE(INJ_STAGE)) u_sig (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_ok),
        .absorb_i   (running),
        .data_i     (resp_i),
        .sig_next_o (sig_next)
    );

    always_comb begin
        running  = (ctl_q.st == ST_RUN);
        start_ok = start_i && (ctl_q.st == ST_IDLE);
        last_idx = ctl_q.zmode ? LAST_ALL : LAST_NZ;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (start_ok) begin
            ctl_d.st    = ST_RUN;
            ctl_d.cnt   = '0;
            ctl_d.zmode = zero_ins_i;
            ctl_d.pass  = 1'b0;
            ctl_d.fail  = 1'b0;
        end else if (running) begin
            if (ctl_q.cnt == last_idx) begin
                ctl_d.st   = ST_IDLE;
                ctl_d.done = 1'b1;
                ctl_d.pass = (sig_next == golden_i);
                ctl_d.fail = (sig_next != golden_i);
            end else begin
                ctl_d.cnt = ctl_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.zmode <= 1'b0;
            ctl_q.done  <= 1'b0;
            ctl_q.pass  <= 1'b0;
            ctl_q.fail  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign serial_o = pattern_o[WIDTH-1];
    assign busy_o   = running;
    assign done_o   = ctl_q.done;
    assign pass_o   = ctl_q.pass;
    assign fail_o   = ctl_q.fail;

    // R7: completion is a single-cycle pulse, never during a run
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8: verdict bits are never both set, and hold while idle
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));
    a_r8_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));

    // R3: every run begins at the seed
    a_r3_seeded: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (pattern_o == ((SEED == '0) ? WIDTH'(1) : SEED)));

    // R9: a start during a run does not restart the count
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && (ctl_q.cnt != last_idx)) |=>
            (busy_o && (ctl_q.cnt == $past(ctl_q.cnt) + CW'(1))));
endmodule

// File: tb/tb_bist_engine.sv
module tb_bist_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       zero_ins_i = 1'b0;
    logic [8:0] resp_i = '0;
    logic [8:0] golden_i = '0;
    logic [8:0] pattern_o;
    logic       serial_o, busy_o, done_o, pass_o, fail_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bist_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .zero_ins_i (zero_ins_i),
        .resp_i     (resp_i),
        .golden_i   (golden_i),
        .pattern_o  (pattern_o),
        .serial_o   (serial_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .pass_o     (pass_o),
        .fail_o     (fail_o)
    );

    // R2 advance: n[0]=s[8], n[5]=s[4]^s[8], others shift up
    function automatic logic [8:0] adv9(input logic [8:0] s);
        logic [8:0] n;
        n = {s[7:0], s[8]};
        n[5] = s[4] ^ s[8];
        return n;
    endfunction

    // R3/R4 sequence with optional zero insertion
    function automatic logic [8:0] next_pat(input logic [8:0] p, input bit zm);
        if (zm && p == 9'h001) return 9'h000;
        if (zm && p == 9'h000) return 9'h002;
        return adv9(p);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_run(input bit zm, input int kind, input bit good);
        logic [8:0] exp_pat;
        logic [8:0] sig_m;
        bit         seen [512];
        int         cyc, mism, distinct, zeros, ser_bad;
        bit         exp_pass;
        for (int i = 0; i < 512; i++) seen[i] = 1'b0;
        exp_pat = 9'h001; sig_m = '0;
        cyc = 0; mism = 0; distinct = 0; zeros = 0; ser_bad = 0;

        @(negedge clk);
        start_i = 1'b1; zero_ins_i = zm;
        @(negedge clk);
        start_i = 1'b0;
        // R8: verdict cleared by the accepted start
        chk(!pass_o && !fail_o, "R8 cleared at start", {pass_o, fail_o}, 0);
        while (busy_o && cyc < 600) begin
            if (pattern_o !== exp_pat) mism++;
            if (serial_o !== pattern_o[8]) ser_bad++;
            if (!seen[pattern_o]) distinct++;
            seen[pattern_o] = 1'b1;
            if (pattern_o == 9'h000) zeros++;
            case (kind)
                1:       resp_i = 9'h000;
                2:       resp_i = 9'h1FF;
                default: resp_i = 9'($urandom);
            endcase
            sig_m   = adv9(sig_m) ^ resp_i;
            golden_i = good ? sig_m : (sig_m ^ (9'h001 << ($urandom % 9)));
            exp_pat = next_pat(exp_pat, zm);
            zero_ins_i = 1'($urandom);          // R5: must not matter
            start_i    = (cyc == 100);          // R9: must be ignored
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        exp_pass = good;
        chk(mism == 0, "R2 pattern sequence", mism, 0);
        chk(ser_bad == 0, "R2 serial equals MSB", ser_bad, 0);
        chk(cyc == (zm ? 512 : 511), "R7/R9 busy length", cyc, zm ? 512 : 511);
        if (zm) begin
            chk(distinct == 512, "R4 distinct patterns", distinct, 512);
            chk(zeros == 1, "R4 zero applied once", zeros, 1);
        end else begin
            chk(distinct == 511, "R3 distinct patterns", distinct, 511);
            chk(zeros == 0, "R3/R5 no zero pattern", zeros, 0);
        end
        chk(done_o == 1'b1, "R7 done after busy falls", done_o, 1);
        chk(pass_o == exp_pass, "R6/R8 pass verdict", pass_o, exp_pass);
        chk(fail_o == !exp_pass, "R8 fail verdict", fail_o, !exp_pass);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
        golden_i = ~golden_i;
        repeat (3) @(negedge clk);
        chk(pass_o == exp_pass && fail_o == !exp_pass, "R8 verdict latched",
            {pass_o, fail_o}, {exp_pass, !exp_pass});
        chk(!busy_o, "R7 idle after run", busy_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7919));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pattern_o == 9'h001, "R1 reset pattern", pattern_o, 1);
        chk(!busy_o && !done_o && !pass_o && !fail_o, "R1 reset flags",
            {busy_o, done_o, pass_o, fail_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pattern_o == 9'h001 && !busy_o, "R1 idle after reset", pattern_o, 1);

        do_run(1'b0, 0, 1'b1);   // random responses, matching golden
        do_run(1'b0, 0, 1'b0);   // single-bit-wrong golden
        do_run(1'b1, 0, 1'b1);   // zero insertion, matching
        do_run(1'b1, 2, 1'b0);   // zero insertion, all-ones responses, wrong golden
        do_run(1'b0, 1, 1'b1);   // all-zero responses: signature stays zero
        do_run(1'b1, 1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule